// File: doc/BRIEF.md
# Pulse-Stepped Program Memory Loader Port

This block is the programming side of a small one-time program store. The store has no address pins. An internal address counter is cleared by a mode code and is then advanced by pulses on a single step pin. One step happens for every group of four pulses. A four-bit mode code on `md` selects one of four operations: clear the address, write, verify (read back) and inhibit. An eight-bit data path carries write data in on `data_i` and read data out on `data_o`. `data_oe` is the tri-state enable for the pad driver.

All pins are sampled on the block clock `clk` and are assumed to be synchronous to it. The step pin must hold each level for at least one `clk` cycle. A programmer clears the address first. For each word it then enters write mode with the word on `data_i`, checks the word in verify mode, and steps to the next location with four pulses. Reading the whole store works the same way, staying in verify mode and pulsing.

Top module: `pp_prom_port`

## Requirements
- R1: The store holds 1002 words of 8 bits. Each location written keeps its own value, independent of the other locations.
- R2: Mode code `md` = 4'b0101 (bit 0 = md[0]) is the clear mode. It forces the address to 0 and the pulse-group count to 0, so the next group starts at pulse one. Step pulses seen while in clear mode do not count.
- R3: Outside clear mode, every rising edge of `pgm_clk` counts one pulse in a group of four. The address increases by one on the falling edge of the third pulse of each group. The first, second and fourth pulses do not move it.
- R4: Mode code 4'b1110 is write mode. The value on `data_i` is stored at the current address once, in the first cycle of the mode. Staying in write mode stores nothing further, and entering the mode again with the same data leaves the same value.
- R5: Mode code 4'b1100 is verify mode. One clock after verify is seen, `data_oe` is 1 and `data_o` carries the word at the current address. Pulsing in verify mode presents successive words in order, one per group.
- R6: In every mode other than verify, `data_oe` is 0 and `data_o` is 0 one clock after the mode is seen.
- R7: Codes 4'b1011 and 4'b1111 (inhibit), and every code not named in R2, R4 or R5, store nothing and drive nothing.
- R8: The address stops at the last location, 1001. Further groups of pulses leave it there and do not wrap it to 0.
- R9: After reset, the address is 0, the pulse count is 0 and `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pgm_clk | input | 1 | Address step pulse pin |
| md | input | 4 | Operation select code, md[0] is the first mode pin |
| data_i | input | 8 | Write data from the pad |
| data_o | output | 8 | Read data to the pad; 0 when not driving |
| data_oe | output | 1 | Pad driver enable, high only in verify mode |

## Verification
The hardest state to reach from the ports is the last location. Getting there takes more than four thousand step pulses after a clear, and the address can only be seen through verify reads. A directed pass therefore clears the address, writes marker words two locations before the end and at the end, and pulses past the end. It then checks that the final read still returns the last marker and has not wrapped back to location 0. The random phase, with a fixed seed, mixes partial pulse groups, repeated write entries, inhibit codes and undefined codes. It keeps a bench model of the address, the pulse count and the stored words, so that each read checks the position in the group as well as the data.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    OP_INHIBIT = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_VERIFY  = 2'd3
  } pp_op_e;

  localparam logic [3:0] CODE_CLEAR  = 4'b0101;
  localparam logic [3:0] CODE_WRITE  = 4'b1110;
  localparam logic [3:0] CODE_VERIFY = 4'b1100;

  // Codes other than the three named ones fall back to inhibit.
  function automatic pp_op_e decode_mode(input logic [3:0] code);
    pp_op_e op;
    case (code)
      CODE_CLEAR:  op = OP_CLEAR;
      CODE_WRITE:  op = OP_WRITE;
      CODE_VERIFY: op = OP_VERIFY;
      default:     op = OP_INHIBIT;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/pp_mode_dec.sv
module pp_mode_dec
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] md,
  output pp_op_e     op,
  output logic       clr,
  output logic       wr_en,
  output logic       vfy
);

  logic in_write_q;
  logic in_write_d;

  always_comb begin
    op         = decode_mode(md);
    clr        = (op == OP_CLEAR);
    vfy        = (op == OP_VERIFY);
    in_write_d = (op == OP_WRITE);
    wr_en      = in_write_d & ~in_write_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_write_q <= 1'b0;
    end else begin
      in_write_q <= in_write_d;
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr, wr_en, vfy})) else $error("operations overlap"); // R7

  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en) else $error("write repeated"); // R4

endmodule

// File: rtl/pp_addr_seq.sv
module pp_addr_seq #(
  parameter int DEPTH     = 1002,
  parameter int GROUP     = 4,
  parameter int STEP_AT   = 3,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pgm_clk,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  STEP_CNT  = CNT_W'(STEP_AT % GROUP);
  localparam logic [CNT_W-1:0]  WRAP_CNT  = CNT_W'(GROUP - 1);

  logic              pin_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rise, fall, at_last;

  always_comb begin
    rise    = pgm_clk & ~pin_q;
    fall    = ~pgm_clk & pin_q;
    at_last = (addr_q == LAST_ADDR);
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    if (clr) begin
      cnt_d  = '0;
      addr_d = '0;
    end else begin
      if (rise) begin
        cnt_d = (cnt_q == WRAP_CNT) ? '0 : cnt_q + CNT_W'(1);
      end
      if (fall && (cnt_q == STEP_CNT) && !at_last) begin
        addr_d = addr_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      pin_q  <= pgm_clk;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST_ADDR) else $error("address past end"); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr_q == '0 && cnt_q == '0)) else $error("clear missed"); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> (addr_q == $past(addr_q) + ADDR_W'(1) || addr_q == '0))
    else $error("address jumped"); // R3

  AST_STEP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == $past(addr_q) + ADDR_W'(1)) |-> ($past(pin_q) && !$past(pgm_clk)))
    else $error("step without falling edge"); // R3

endmodule

// File: rtl/pp_store.sv
module pp_store #(
  parameter int DEPTH   = 1002,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              vfy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              oe_q, oe_d;

  // Array storage carries no reset, as a macro would.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_comb begin
    oe_d    = vfy;
    rdata_d = vfy ? mem[addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      oe_q    <= oe_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign oe    = oe_q;

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (rdata_q == '0)) else $error("bus not quiet"); // R6

  AST_NO_WRITE_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && vfy)) else $error("write during verify"); // R7

endmodule

// File: rtl/pp_prom_port.sv
module pp_prom_port
  import pp_pkg::*;
#(
  parameter int DEPTH   = 1002,
  parameter int DATA_W  = 8,
  parameter int GROUP   = 4,
  parameter int STEP_AT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_clk,
  input  logic [3:0]        md,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic              rst_meta_q, rst_sync_q;
  pp_op_e            op;
  logic              clr, wr_en, vfy;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pp_mode_dec i_mode_dec (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .md    (md),
    .op    (op),
    .clr   (clr),
    .wr_en (wr_en),
    .vfy   (vfy)
  );

  pp_addr_seq #(
    .DEPTH   (DEPTH),
    .GROUP   (GROUP),
    .STEP_AT (STEP_AT)
  ) i_addr_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clr     (clr),
    .pgm_clk (pgm_clk),
    .addr    (addr)
  );

  pp_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) i_store (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .wr_en (wr_en),
    .vfy   (vfy),
    .addr  (addr),
    .wdata (data_i),
    .rdata (data_o),
    .oe    (data_oe)
  );

  AST_OE_VERIFY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    data_oe |-> ($past(op) == OP_VERIFY)) else $error("driving outside verify"); // R5

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($past(op) == OP_VERIFY) |-> data_oe) else $error("verify not driving"); // R5

endmodule

// File: tb/test_pp_prom_port.sv
`timescale 1ns/1ps
module test_pp_prom_port;

  localparam int DEPTH = 1002;
  localparam logic [3:0] M_CLR = 4'b0101;
  localparam logic [3:0] M_WR  = 4'b1110;
  localparam logic [3:0] M_VFY = 4'b1100;
  localparam logic [3:0] M_INH = 4'b1011;

  logic       clk;
  logic       rst_n;
  logic       pgm_clk;
  logic [3:0] md;
  logic [7:0] data_i;
  logic [7:0] data_o;
  logic       data_oe;

  int checks;
  int errors;
  bit finished;

  int         m_addr;
  int         m_cnt;
  int         m_op;
  logic [7:0] shadow [DEPTH];
  bit         valid  [DEPTH];

  pp_prom_port i_pp_prom_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .pgm_clk (pgm_clk),
    .md      (md),
    .data_i  (data_i),
    .data_o  (data_o),
    .data_oe (data_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // 0 inhibit, 1 clear, 2 write, 3 verify
  function automatic int exp_op(input logic [3:0] code);
    if (code == M_CLR) return 1;
    if (code == M_WR)  return 2;
    if (code == M_VFY) return 3;
    return 0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] code, input logic [7:0] d);
    int nop;
    nop = exp_op(code);
    md = code;
    data_i = d;
    if (nop == 2 && m_op != 2) begin
      shadow[m_addr] = d;
      valid[m_addr]  = 1'b1;
    end
    if (nop == 1) begin
      m_addr = 0;
      m_cnt  = 0;
    end
    m_op = nop;
    cyc(2);
  endtask

  task automatic pulse();
    pgm_clk = 1'b1;
    if (m_op != 1) m_cnt = (m_cnt + 1) % 4;
    cyc(2);
    pgm_clk = 1'b0;
    if (m_op != 1 && m_cnt == 3 && m_addr < DEPTH - 1) m_addr++;
    cyc(2);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic read_check(input string tag);
    set_mode(M_VFY, 8'h00);
    check(data_oe === 1'b1, {tag, " R5 oe"}, int'(data_oe), 1);
    if (valid[m_addr])
      check(data_o === shadow[m_addr], {tag, " R5 data"}, int'(data_o), int'(shadow[m_addr]));
  endtask

  task automatic quiet_check(input string tag);
    check(data_oe === 1'b0 && data_o === 8'h00, {tag, " R6 bus quiet"},
          int'({data_oe, data_o}), 0);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] code;
    int sel;
    void'($urandom(32'h5eed_0042));
    checks = 0; errors = 0; finished = 0;
    for (int i = 0; i < DEPTH; i++) valid[i] = 1'b0;
    m_addr = 0; m_cnt = 0; m_op = 0;
    rst_n = 1'b0; pgm_clk = 1'b0; md = M_INH; data_i = 8'h00;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);

    // R9 reset state
    check(data_oe === 1'b0, "R9 oe after reset", int'(data_oe), 0);
    check(data_o === 8'h00, "R9 data after reset", int'(data_o), 0);
    set_mode(M_WR, 8'h5A);
    set_mode(M_INH, 8'hFF);
    set_mode(M_CLR, 8'h00);
    read_check("R9 address zero after reset");

    // R3 partial groups: two pulses stay, third falling edge steps, fourth stays
    set_mode(M_CLR, 8'h00);
    set_mode(M_INH, 8'h00);
    pulses(1);
    set_mode(M_WR, 8'h11);
    pulses(1);
    set_mode(M_INH, 8'h00);
    pulses(1);
    set_mode(M_WR, 8'h22);
    set_mode(M_INH, 8'h00);
    pulses(1);
    set_mode(M_WR, 8'h33);
    set_mode(M_CLR, 8'h00);
    read_check("R3 word0 after partial group");
    check(shadow[0] == 8'h11 && shadow[1] == 8'h33, "R3 model layout",
          int'({shadow[0], shadow[1]}), 16'h1133);
    pulses(3);
    read_check("R3 word1 on third fall");

    // R2 pulses during clear ignored, grouping restarts at pulse one
    set_mode(M_CLR, 8'h00);
    pulses(5);
    set_mode(M_INH, 8'h00);
    pulses(2);
    read_check("R2 clear holds address 0");
    pulses(1);
    read_check("R2 group restarts after clear");

    // R4 repeated entry with the same value; staying in write stores nothing new
    set_mode(M_CLR, 8'h00);
    set_mode(M_WR, 8'h6C);
    data_i = 8'h99;
    cyc(3);
    set_mode(M_INH, 8'h00);
    set_mode(M_WR, 8'h6C);
    set_mode(M_INH, 8'h00);
    read_check("R4 value held");

    // R7 inhibit codes and an undefined code store nothing
    set_mode(4'b1111, 8'hE1);
    quiet_check("R7 inhibit 1111");
    set_mode(4'b0000, 8'hE2);
    quiet_check("R7 undefined 0000");
    read_check("R7 no write from inhibit");

    // R8 saturation at the last location; R1 separate words
    set_mode(M_CLR, 8'h00);
    set_mode(M_INH, 8'h00);
    pulses(4 * (DEPTH - 3));
    set_mode(M_WR, 8'hA5);
    set_mode(M_INH, 8'h00);
    pulses(8);
    set_mode(M_WR, 8'hC3);
    set_mode(M_INH, 8'h00);
    check(m_addr == DEPTH - 1, "R8 model at last", m_addr, DEPTH - 1);
    pulses(12);
    read_check("R8 saturated last word");
    set_mode(M_CLR, 8'h00);
    read_check("R1 word0 intact after end");
    pulses(4 * (DEPTH - 3));
    read_check("R1 word at last-2");
    pulses(8);
    read_check("R5 sequential read to last");

    // random phase
    set_mode(M_CLR, 8'h00);
    for (int it = 0; it < 400; it++) begin
      sel = $urandom % 7;
      d = 8'($urandom);
      case (sel)
        0: pulses(1 + ($urandom % 6));
        1: begin set_mode(M_WR, d); set_mode(M_INH, 8'h00); end
        2, 6: read_check("R5 random read");
        3: begin
             set_mode(($urandom % 2) ? 4'b1011 : 4'b1111, d);
             quiet_check("R7 random inhibit");
           end
        4: begin
             code = 4'($urandom);
             if (code == M_VFY || code == M_CLR) code = 4'b0110;
             set_mode(code, d);
             if (exp_op(code) != 3) quiet_check("R6 random code");
           end
        default: if ($urandom % 4 == 0) set_mode(M_CLR, 8'h00);
      endcase
    end
    set_mode(M_INH, 8'h00);
    quiet_check("R6 final");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule